// File: doc/BRIEF.md
# Round-Robin Station Polling Sequencer

This block is the control sequencer of a master station that serves a fixed set of remote stations in repeated polling rounds. A round opens with one broadcast alignment frame. The stations are then served in fixed-size groups, in ascending address order. For each group the sequencer requests one data frame per station, waits for the frame layer to confirm each transmission, and then opens a bounded window in which it collects acknowledgements from that group.

A window closes early once every station of the group has answered. Otherwise it closes when a deadlock timer expires. The timer length is the expected transfer time, stations × (alignment cycles + burst cycles × bursts), plus a margin. Stations that stay silent are recorded in a missing-acknowledge bitmap. The end of the round is signalled by a single-cycle strobe.

A new round begins only when a start input is seen while the sequencer is idle. Holding start high gives free-running operation; pulsing it gives externally paced rounds. Station addresses run from 1 to `NUM_STA`, and address 0 is the broadcast destination. Destination and source addresses are 8 bits wide.

Top module: `poll_sequencer`

## Requirements
- R1: While reset is held and right after it, `tx_req_o` and `cycle_done_o` are low and `miss_map_o` is all zeros.
- R2: From idle, a round starts only on a clock edge where `start_i` is high; with `start_i` low the sequencer stays idle and requests nothing.
- R3: The first frame of every round has kind code 1 (alignment) and destination 0 (broadcast).
- R4: After the alignment frame, data frames (kind code 2) go out group by group (default group size 4); group g carries destinations g*GRP+1 up to g*GRP+GRP (capped at NUM_STA) in ascending order.
- R5: A frame request stays asserted with unchanged kind and destination until `tx_done_i` is seen high on a clock edge.
- R6: When the last outstanding station of the current group is acknowledged on a clock edge, the window closes at that edge, and the next request (or the end strobe) is visible in the following cycle.
- R7: A window that does not complete lasts exactly TIMEOUT = GRP*(8+4*1)+MARGIN cycles (64 by default); an acknowledgement in any of those cycles, including the last, counts.
- R8: Acknowledgements whose source is not a station of the current group are ignored, and repeated acknowledgements from one station count once.
- R9: Bit i of `miss_map_o` is set when station address i+1 did not acknowledge within its window; the map is cleared when a start is accepted and is otherwise held, including after the round ends.
- R10: After the last group's window closes, `cycle_done_o` is high for exactly one cycle with `tx_req_o` low, and the sequencer then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a polling round (sampled in idle) |
| tx_req_o | output | 1 | Frame transmit request |
| tx_kind_o | output | 2 | Frame kind: 1 alignment, 2 data |
| tx_dest_o | output | 8 | Frame destination address (0 = broadcast) |
| tx_done_i | input | 1 | Frame layer has sent the requested frame |
| ack_valid_i | input | 1 | An acknowledgement frame was received |
| ack_src_i | input | 8 | Source address of the received acknowledgement |
| miss_map_o | output | NUM_STA | Stations that failed to acknowledge, bit i = address i+1 |
| cycle_done_o | output | 1 | One-cycle strobe at the end of a round |

## Verification
Every result is due on a fixed cycle count after its stimulus. The next request follows one clock edge after a `tx_done_i` edge. A complete group ends its window on the edge that captures its last acknowledgement. A silent window takes exactly 64 edges. The bench drives inputs on falling edges and, from the first cycle of each window, counts falling edges until a request or the end strobe appears; it compares that count with the value computed from the acknowledgement schedule, and it samples the bitmap in the strobe cycle.

// File: rtl/poll_pkg.sv
package poll_pkg;

    localparam int ADDR_BITS = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_DATA,
        ST_COLLECT,
        ST_END
    } poll_state_e;

    typedef enum logic [1:0] {
        FR_NONE  = 2'd0,
        FR_ALIGN = 2'd1,
        FR_DATA  = 2'd2
    } frame_kind_e;

    typedef struct packed {
        logic                  valid;
        frame_kind_e           kind;
        logic [ADDR_BITS-1:0]  dest;
    } frame_req_t;

    // expected transfer time of one group plus a safety margin
    function automatic int window_cycles(int grp, int align_c, int burst_c,
                                         int bursts, int margin);
        return grp * (align_c + burst_c * bursts) + margin;
    endfunction

endpackage

// File: rtl/window_timer.sv
module window_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/ack_tracker.sv
module ack_tracker #(
    parameter int GRP    = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [ADDR_W-1:0] base,
    input  logic [GRP-1:0]    member,
    input  logic              ack_valid,
    input  logic [ADDR_W-1:0] ack_src,
    output logic              all_seen,
    output logic [GRP-1:0]    missing
);
    logic [GRP-1:0] seen_q;
    logic [GRP-1:0] seen_nxt;
    int             offset;
    logic           hit;

    always_comb begin
        offset = int'(ack_src) - int'(base);
        hit    = enable && ack_valid && (offset >= 0) && (offset < GRP);
    end

    for (genvar i = 0; i < GRP; i++) begin : g_slot
        assign seen_nxt[i] = seen_q[i] | (hit && (offset == i) && member[i]);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            seen_q <= '0;
        end else begin
            seen_q <= seen_nxt;
        end
    end

    assign all_seen = &(seen_nxt | ~member);
    assign missing  = member & ~seen_nxt;
endmodule

// File: rtl/poll_sequencer.sv
module poll_sequencer
    import poll_pkg::*;
#(
    parameter int NUM_STA   = 8,
    parameter int GRP       = 4,
    parameter int ALIGN_CYC = 8,
    parameter int BURST_CYC = 4,
    parameter int BURSTS    = 1,
    parameter int MARGIN    = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    output logic                 tx_req_o,
    output logic [1:0]           tx_kind_o,
    output logic [ADDR_BITS-1:0] tx_dest_o,
    input  logic                 tx_done_i,
    input  logic                 ack_valid_i,
    input  logic [ADDR_BITS-1:0] ack_src_i,
    output logic [NUM_STA-1:0]   miss_map_o,
    output logic                 cycle_done_o
);
    localparam int NUM_GRP = (NUM_STA + GRP - 1) / GRP;
    localparam int GIDX_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
    localparam int SLOT_W  = (GRP > 1) ? $clog2(GRP) : 1;
    localparam int TIMEOUT = window_cycles(GRP, ALIGN_CYC, BURST_CYC, BURSTS, MARGIN);

    poll_state_e          state_q;
    logic [GIDX_W-1:0]    grp_q;
    logic [SLOT_W-1:0]    slot_q;
    logic [NUM_STA-1:0]   miss_q;
    logic [ADDR_BITS-1:0] base;
    logic [GRP-1:0]       member;
    logic                 last_slot;
    logic                 last_grp;
    logic                 collecting;
    logic                 all_seen;
    logic                 expired;
    logic                 win_end;
    logic [GRP-1:0]       grp_missing;
    logic [NUM_STA-1:0]   miss_set;
    frame_req_t           req;

    assign base       = ADDR_BITS'(int'(grp_q) * GRP + 1);
    assign last_slot  = (int'(slot_q) == GRP - 1) || (int'(base) + int'(slot_q) == NUM_STA);
    assign last_grp   = (int'(grp_q) == NUM_GRP - 1);
    assign collecting = (state_q == ST_COLLECT);
    assign win_end    = collecting && (all_seen || expired);

    for (genvar i = 0; i < GRP; i++) begin : g_member
        assign member[i] = (int'(base) + i <= NUM_STA);
    end

    for (genvar s = 0; s < NUM_STA; s++) begin : g_miss
        assign miss_set[s] = win_end && (int'(grp_q) == s / GRP) && grp_missing[s % GRP];
    end

    ack_tracker #(
        .GRP    (GRP),
        .ADDR_W (ADDR_BITS)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .enable    (collecting),
        .base      (base),
        .member    (member),
        .ack_valid (ack_valid_i),
        .ack_src   (ack_src_i),
        .all_seen  (all_seen),
        .missing   (grp_missing)
    );

    window_timer #(
        .LIMIT (TIMEOUT)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (collecting),
        .expired (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            grp_q   <= '0;
            slot_q  <= '0;
            miss_q  <= '0;
        end else begin
            miss_q <= miss_q | miss_set;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_ALIGN;
                        miss_q  <= '0;
                    end
                end
                ST_ALIGN: begin
                    if (tx_done_i) begin
                        state_q <= ST_DATA;
                        grp_q   <= '0;
                        slot_q  <= '0;
                    end
                end
                ST_DATA: begin
                    if (tx_done_i) begin
                        if (last_slot) begin
                            state_q <= ST_COLLECT;
                        end else begin
                            slot_q <= slot_q + 1'b1;
                        end
                    end
                end
                ST_COLLECT: begin
                    if (win_end) begin
                        slot_q <= '0;
                        if (last_grp) begin
                            state_q <= ST_END;
                        end else begin
                            state_q <= ST_DATA;
                            grp_q   <= grp_q + 1'b1;
                        end
                    end
                end
                ST_END: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req = '{valid: 1'b0, kind: FR_NONE, dest: '0};
        if (state_q == ST_ALIGN) begin
            req = '{valid: 1'b1, kind: FR_ALIGN, dest: '0};
        end else if (state_q == ST_DATA) begin
            req = '{valid: 1'b1, kind: FR_DATA, dest: base + ADDR_BITS'(slot_q)};
        end
    end

    assign tx_req_o     = req.valid;
    assign tx_kind_o    = req.kind;
    assign tx_dest_o    = req.dest;
    assign miss_map_o   = miss_q;
    assign cycle_done_o = (state_q == ST_END);
endmodule

// File: rtl/poll_seq_chk.sv
module poll_seq_chk #(
    parameter int NUM_STA = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               start_i,
    input logic               tx_req_o,
    input logic [1:0]         tx_kind_o,
    input logic [7:0]         tx_dest_o,
    input logic               tx_done_i,
    input logic [NUM_STA-1:0] miss_map_o,
    input logic               cycle_done_o
);
    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_req_o && !tx_done_i) |=> (tx_req_o && $stable(tx_kind_o) && $stable(tx_dest_o)));

    // R10
    end_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cycle_done_o |=> !cycle_done_o);

    // R10
    end_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cycle_done_o |-> !tx_req_o);

    // R3
    align_bcast_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_req_o && tx_kind_o == 2'd1) |-> (tx_dest_o == 8'd0));

    // R4
    data_dest_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_req_o && tx_kind_o == 2'd2) |-> (tx_dest_o != 8'd0 && int'(tx_dest_o) <= NUM_STA));

    // R9
    miss_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> ((miss_map_o & $past(miss_map_o)) == $past(miss_map_o)));
endmodule

bind poll_sequencer poll_seq_chk #(.NUM_STA(NUM_STA)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .tx_req_o     (tx_req_o),
    .tx_kind_o    (tx_kind_o),
    .tx_dest_o    (tx_dest_o),
    .tx_done_i    (tx_done_i),
    .miss_map_o   (miss_map_o),
    .cycle_done_o (cycle_done_o)
);

// File: tb/poll_sequencer_tb.sv
module poll_sequencer_tb;
    localparam int N       = 8;
    localparam int G       = 4;
    localparam int TIMEOUT = 4 * (8 + 4 * 1) + 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       tx_req_o;
    logic [1:0] tx_kind_o;
    logic [7:0] tx_dest_o;
    logic       tx_done_i = 1'b0;
    logic       ack_valid_i = 1'b0;
    logic [7:0] ack_src_i = '0;
    logic [N-1:0] miss_map_o;
    logic       cycle_done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    poll_sequencer u_dut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .tx_req_o     (tx_req_o),
        .tx_kind_o    (tx_kind_o),
        .tx_dest_o    (tx_dest_o),
        .tx_done_i    (tx_done_i),
        .ack_valid_i  (ack_valid_i),
        .ack_src_i    (ack_src_i),
        .miss_map_o   (miss_map_o),
        .cycle_done_o (cycle_done_o)
    );

    // {ack mask[17:10], delay[9:2], duplicate[1], stray[0]}; mask bit i = address i+1
    localparam logic [17:0] VEC [6] = '{
        {8'hFF, 8'd0,  1'b0, 1'b0},
        {8'h00, 8'd0,  1'b0, 1'b0},
        {8'h0F, 8'd0,  1'b0, 1'b0},
        {8'hA5, 8'd3,  1'b1, 1'b1},
        {8'hFF, 8'd10, 1'b1, 1'b1},
        {8'h81, 8'd63, 1'b0, 1'b0}
    };

    task automatic check(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic serve_frame(input int kind, input int dest, input int hold, input string req);
        int guard = 0;
        while (!tx_req_o && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        check(tx_req_o, req, int'(tx_req_o), 1);
        check(int'(tx_kind_o) == kind, req, int'(tx_kind_o), kind);
        check(int'(tx_dest_o) == dest, req, int'(tx_dest_o), dest);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check(tx_req_o && int'(tx_dest_o) == dest, "R5 hold", int'(tx_dest_o), dest);
        end
        tx_done_i = 1'b1;
        @(negedge clk);
        tx_done_i = 1'b0;
    endtask

    task automatic begin_round();
        start_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_round(input logic [17:0] v, input int align_hold);
        logic [7:0] mask;
        int d;
        bit dup;
        bit stray;
        int sched [8];
        int t;
        int a;
        int n;
        int exp_n;
        mask  = v[17:10];
        d     = int'(v[9:2]);
        dup   = v[1];
        stray = v[0];
        begin_round();
        serve_frame(1, 0, align_hold, "R3 align frame");
        check(miss_map_o == '0, "R9 clear on start", int'(miss_map_o), 0);
        for (int g = 0; g < N / G; g++) begin
            for (int j = 0; j < G; j++) begin
                serve_frame(2, g * G + j + 1, 0, "R4 data frame");
            end
            t = 0;
            a = 0;
            if (stray) begin
                sched[t] = (g == 0) ? 5 : 1;
                t++;
            end
            for (int j = 0; j < G; j++) begin
                if (mask[g * G + j]) begin
                    sched[t] = g * G + j + 1;
                    t++;
                    if (dup && a == 0) begin
                        sched[t] = g * G + j + 1;
                        t++;
                    end
                    a++;
                end
            end
            exp_n = (a == G) ? d + t : TIMEOUT;
            n = 0;
            while (!(tx_req_o || cycle_done_o) && n < 200) begin
                if (n >= d && n - d < t) begin
                    ack_valid_i = 1'b1;
                    ack_src_i   = 8'(sched[n - d]);
                end else begin
                    ack_valid_i = 1'b0;
                end
                @(negedge clk);
                n++;
            end
            ack_valid_i = 1'b0;
            if (a == G) begin
                check(n == exp_n, "R6 early close", n, exp_n);
            end else begin
                check(n == exp_n, "R7 window length", n, exp_n);
            end
            if (g == N / G - 1) begin
                check(cycle_done_o && !tx_req_o, "R10 end strobe", int'(cycle_done_o), 1);
                check(miss_map_o == ~mask, "R9 R8 missing map", int'(miss_map_o), int'(~mask));
            end else begin
                check(!cycle_done_o, "R10 no early strobe", int'(cycle_done_o), 0);
            end
        end
        @(negedge clk);
        check(!cycle_done_o && !tx_req_o, "R10 single pulse", int'(cycle_done_o), 0);
        check(miss_map_o == ~mask, "R9 held", int'(miss_map_o), int'(~mask));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!tx_req_o && !cycle_done_o, "R1 outputs in reset", int'(tx_req_o), 0);
        check(miss_map_o == '0, "R1 map in reset", int'(miss_map_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!tx_req_o && miss_map_o == '0, "R1 after reset", int'(tx_req_o), 0);

        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check(!tx_req_o, "R2 idle without start", int'(tx_req_o), 0);
        end

        for (int i = 0; i < 6; i++) begin
            run_round(VEC[i], (i == 1) ? 3 : 0);
        end

        // map persists while idle, then the next round clears it
        repeat (10) @(negedge clk);
        check(miss_map_o == 8'h7E, "R9 held while idle", int'(miss_map_o), 8'h7E);
        check(!tx_req_o, "R2 no round without start", int'(tx_req_o), 0);
        run_round(VEC[0], 5);

        finished = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!finished && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected finish", cyc);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule